// File: doc/BRIEF.md
# Eight-level priority interrupt controller

This block collects interrupt requests from eight input lines, keeps them pending, filters them through a per-line mask and raises one interrupt line towards the processor. The request forwarded is the best pending unmasked one, and only if it outranks every level already in service. When the processor pulses the acknowledge input, the winning level moves from the pending set into the in-service set. A vector is then presented on a dedicated output. The vector is a programmable base plus the level number times a selectable spacing of 4 or 8.

A host reaches the block through a small register port with a one-bit address. Address 1 holds the mask. Address 0 takes commands (configuration, vector base, end of service) and returns either the pending or the in-service set. Requests can be captured on rising edges or followed as levels. Priority can be fixed, with line 0 highest and line 7 lowest, or rotating, where each level that finishes service drops to lowest priority.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the vector output is 0, the pending, in-service and mask sets are empty, edge capture, rotation and the 8-step spacing are off, the vector base is 0, and level 7 is the lowest rotating priority.
- R2: In edge mode (configuration bit 0 = 1), a line sets its pending bit on a low-to-high transition. The bit stays set until that level is acknowledged. A line held high does not set it again until it has gone low and risen once more.
- R3: In level mode (configuration bit 0 = 0), each pending bit follows its input line with one clock of delay. Only the cycle after an acknowledge differs: the acknowledged bit reads 0 in that cycle.
- R4: A mask bit set to 1 keeps its line out of priority selection, so that line never raises the interrupt output or wins an acknowledge. The line's pending bit is still recorded, and other lines are served normally.
- R5: With fixed priority (configuration bit 1 = 0), the lowest-numbered eligible line wins.
- R6: An acknowledge while the interrupt output is high does three things: it sets the winner's in-service bit, clears its pending bit, and updates the vector output on the next clock. The new vector is base + level × spacing, modulo 256. The spacing is 8 when configuration bit 2 = 1 and 4 otherwise. The base is written as a command with data[7:6] = 01 and equals data[5:0] × 4. An acknowledge while the interrupt output is low changes nothing.
- R7: The interrupt output is high only when the best eligible pending level has strictly higher priority than every in-service level. An equal or lower level waits.
- R8: An end-of-service command (data[7:6] = 10 at address 0) clears the in-service bit of the highest-priority level in service. It does nothing when the in-service set is empty.
- R9: With rotating priority (configuration bit 1 = 1), the level cleared by an end-of-service command becomes lowest priority. The next level up (modulo 8) becomes highest.
- R10: A host write at address 1 loads the mask from data[7:0]. A write at address 0 with data[7:6] = 00 loads configuration bits [3:0] (bit 3 chooses the in-service set for reads). A write with data[7:6] = 11 has no effect. A read at address 1 returns the mask. A read at address 0 returns the pending set when bit 3 = 0 and the in-service set when bit 3 = 1.
- R11: An acknowledge and an end-of-service command in the same cycle both take effect. The command clears the highest-priority level in service before the acknowledge, and the acknowledge adds the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_i | input | 8 | Interrupt request lines, bit n is level n |
| host_cs_i | input | 1 | Host access select |
| host_wr_i | input | 1 | Host write strobe (one cycle per write) |
| host_addr_i | input | 1 | Host register select |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, zero when not selected |
| int_o | output | 1 | Interrupt request to the processor |
| int_ack_i | input | 1 | Acknowledge pulse from the processor |
| vector_o | output | 8 | Vector of the most recently acknowledged level |

## Verification
An acknowledge and an end-of-service command can land on the same clock edge. Both change the in-service set, and one of them also changes the pending set. The bench builds this case by putting level 3 in service and raising line 1, which is allowed to preempt. It then drives the acknowledge and an end-of-service write together. The in-service set read back must be exactly level 1, the vector must be the one for level 1, and level 3 must have been cleared rather than the new level.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        OP_CFG  = 2'b00,
        OP_BASE = 2'b01,
        OP_EOI  = 2'b10,
        OP_NOP  = 2'b11
    } host_op_e;

    // bit order matches host data bits [3:0]
    typedef struct packed {
        logic rd_isr;
        logic iv8;
        logic rotate;
        logic edge_mode;
    } cfg_t;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int NUM_LVL = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] ir_i,
    input  logic               edge_mode_i,
    input  logic [NUM_LVL-1:0] clr_i,
    output logic [NUM_LVL-1:0] irr_o
);

    typedef struct packed {
        logic [NUM_LVL-1:0] irr;
        logic [NUM_LVL-1:0] prev;
    } cap_t;

    cap_t s_d, s_q;
    logic [NUM_LVL-1:0] rise;

    always_comb begin
        s_d      = s_q;
        rise     = ir_i & ~s_q.prev;
        s_d.prev = ir_i;
        if (edge_mode_i) begin
            s_d.irr = (s_q.irr & ~clr_i) | rise;
        end else begin
            s_d.irr = ir_i & ~clr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irr_o = s_q.irr;

    // R2: in edge mode a pending bit only appears after a low-to-high input
    a_r2_edge_only: assert property (@(posedge clk) disable iff (rst)
        $past(edge_mode_i) |->
            ((s_q.irr & ~$past(s_q.irr)) & ~($past(ir_i) & ~$past(s_q.prev))) == '0);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_LVL = 8,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] vec_i,
    input  logic               rotate_i,
    input  logic [LW-1:0]      low_i,
    output logic               any_o,
    output logic [LW-1:0]      idx_o,
    output logic [LW-1:0]      rank_o
);

    // walk from the worst rank to the best so the best match is kept last
    always_comb begin : pick
        logic [LW-1:0] lvl;
        any_o  = 1'b0;
        idx_o  = '0;
        rank_o = '0;
        lvl    = '0;
        for (int r = NUM_LVL - 1; r >= 0; r--) begin
            lvl = rotate_i ? (low_i + LW'(r) + LW'(1)) : LW'(r);
            if (vec_i[lvl]) begin
                any_o  = 1'b1;
                idx_o  = lvl;
                rank_o = LW'(r);
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LVL = 8,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] ir_i,
    input  logic               host_cs_i,
    input  logic               host_wr_i,
    input  logic               host_addr_i,
    input  logic [DW-1:0]      host_wdata_i,
    output logic [DW-1:0]      host_rdata_o,
    output logic               int_o,
    input  logic               int_ack_i,
    output logic [DW-1:0]      vector_o
);

    localparam int LW     = $clog2(NUM_LVL);
    localparam int BASE_W = DW - 2;

    typedef struct packed {
        logic [NUM_LVL-1:0] imr;
        logic [NUM_LVL-1:0] isr;
        cfg_t               cfg;
        logic [DW-1:0]      base;
        logic [LW-1:0]      low;
        logic [DW-1:0]      vec;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_LVL-1:0] irr, ack_bit, eligible;
    logic               req_any, isr_any, take, wr_cmd, wr_mask, eoi;
    logic [LW-1:0]      req_idx, req_rank, isr_idx, isr_rank;
    host_op_e           op;

    assign wr_cmd   = host_cs_i && host_wr_i && !host_addr_i;
    assign wr_mask  = host_cs_i && host_wr_i && host_addr_i;
    assign op       = host_op_e'(host_wdata_i[DW-1 -: 2]);
    assign eoi      = wr_cmd && (op == OP_EOI);
    assign eligible = irr & ~s_q.imr;

    irq_req_capture #(.NUM_LVL(NUM_LVL)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .ir_i        (ir_i),
        .edge_mode_i (s_q.cfg.edge_mode),
        .clr_i       (ack_bit),
        .irr_o       (irr)
    );

    irq_prio_pick #(.NUM_LVL(NUM_LVL)) u_pick_req (
        .vec_i    (eligible),
        .rotate_i (s_q.cfg.rotate),
        .low_i    (s_q.low),
        .any_o    (req_any),
        .idx_o    (req_idx),
        .rank_o   (req_rank)
    );

    irq_prio_pick #(.NUM_LVL(NUM_LVL)) u_pick_isr (
        .vec_i    (s_q.isr),
        .rotate_i (s_q.cfg.rotate),
        .low_i    (s_q.low),
        .any_o    (isr_any),
        .idx_o    (isr_idx),
        .rank_o   (isr_rank)
    );

    assign int_o   = req_any && (!isr_any || (req_rank < isr_rank));
    assign take    = int_ack_i && int_o;
    assign ack_bit = take ? (NUM_LVL'(1) << req_idx) : '0;

    always_comb begin
        s_d = s_q;
        if (wr_mask) begin
            s_d.imr = host_wdata_i[NUM_LVL-1:0];
        end
        if (wr_cmd) begin
            case (op)
                OP_CFG:  s_d.cfg  = cfg_t'(host_wdata_i[3:0]);
                OP_BASE: s_d.base = {host_wdata_i[BASE_W-1:0], 2'b00};
                OP_EOI: begin
                    if (isr_any) begin
                        s_d.isr[isr_idx] = 1'b0;
                        if (s_q.cfg.rotate) begin
                            s_d.low = isr_idx;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (take) begin
            s_d.isr[req_idx] = 1'b1;
            s_d.vec = s_q.base + (DW'(req_idx) << (s_q.cfg.iv8 ? 3 : 2));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q     <= '0;
            s_q.low <= LW'(NUM_LVL - 1);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (!host_cs_i) begin
            host_rdata_o = '0;
        end else if (host_addr_i) begin
            host_rdata_o = DW'(s_q.imr);
        end else begin
            host_rdata_o = DW'(s_q.cfg.rd_isr ? s_q.isr : irr);
        end
    end

    assign vector_o = s_q.vec;

    // R6: a taken acknowledge grows the in-service set by one level
    a_r6_ack_adds_one: assert property (@(posedge clk) disable iff (rst)
        (take && !eoi) |=> $countones(s_q.isr) == $past($countones(s_q.isr)) + 1);

    // R6: the vector only moves on a taken acknowledge
    a_r6_vector_held: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(vector_o));

    // R8: end of service removes exactly one level
    a_r8_eoi_removes_one: assert property (@(posedge clk) disable iff (rst)
        (eoi && (s_q.isr != '0) && !take) |=> $countones(s_q.isr) == $past($countones(s_q.isr)) - 1);

    // R4: a masked line never enters service
    a_r4_masked_not_served: assert property (@(posedge clk) disable iff (rst)
        take |=> ((s_q.isr & ~$past(s_q.isr)) & $past(s_q.imr)) == '0);

    // R7: the winner of an acknowledge is never already in service
    a_r7_no_reentry: assert property (@(posedge clk) disable iff (rst)
        take |-> (s_q.isr & ack_bit) == '0);

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ir = '0;
    logic       cs = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       int_o;
    logic       ack = 1'b0;
    logic [7:0] vec;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] cfg_cur = 8'h00;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       took = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .ir_i         (ir),
        .host_cs_i    (cs),
        .host_wr_i    (wr),
        .host_addr_i  (addr),
        .host_wdata_i (wdata),
        .host_rdata_o (rdata),
        .int_o        (int_o),
        .int_ack_i    (ack),
        .vector_o     (vec)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; addr = 1'b0; wdata = '0;
    endtask

    task automatic host_read(input logic a, output logic [7:0] d);
        cs = 1'b1; wr = 1'b0; addr = a;
        #2;
        d = rdata;
        cs = 1'b0; addr = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] d);
        cfg_cur = d & 8'h07;
        host_write(1'b0, cfg_cur);
    endtask

    task automatic read_pending(output logic [7:0] d);
        host_write(1'b0, cfg_cur);
        host_read(1'b0, d);
    endtask

    task automatic read_isr(output logic [7:0] d);
        host_write(1'b0, cfg_cur | 8'h08);
        host_read(1'b0, d);
        host_write(1'b0, cfg_cur);
    endtask

    task automatic set_ir(input logic [7:0] v);
        @(negedge clk);
        ir = v;
        @(negedge clk);
    endtask

    task automatic eoi();
        host_write(1'b0, 8'h80);
    endtask

    // driver: pushes the expected vector, then pulses acknowledge
    task automatic do_ack(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic ack_with_eoi(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        ack = 1'b1; cs = 1'b1; wr = 1'b1; addr = 1'b0; wdata = 8'h80;
        @(negedge clk);
        ack = 1'b0; cs = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    // monitor: a quarter cycle before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (took) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL R6 unexpected acknowledge actual=%0h expected=none", vec);
                end else begin
                    chk(tag_q.pop_front(), vec, exp_q.pop_front());
                end
            end
            took = ack && int_o;
        end
    end

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 int after reset", {7'd0, int_o}, 8'h00);
        chk("R1 vector after reset", vec, 8'h00);
        host_read(1'b0, rd); chk("R1 pending after reset", rd, 8'h00);
        host_read(1'b1, rd); chk("R1 mask after reset", rd, 8'h00);

        // R10 base command and a no-op command
        host_write(1'b0, 8'h48);
        host_write(1'b0, 8'hFF);
        set_cfg(8'h01);

        // R2 edge capture, R5 fixed priority
        set_ir(8'h24);
        chk("R2 int after edges", {7'd0, int_o}, 8'h01);
        read_pending(rd); chk("R2 pending after edges", rd, 8'h24);
        do_ack(8'h28, "R5 fixed winner level 2 vector");
        chk("R7 lower level blocked", {7'd0, int_o}, 8'h00);
        read_isr(rd); chk("R6 in-service after ack", rd, 8'h04);
        read_pending(rd); chk("R6 pending after ack", rd, 8'h20);

        // R7 higher level preempts
        set_ir(8'h26);
        chk("R7 higher level preempts", {7'd0, int_o}, 8'h01);
        do_ack(8'h24, "R7 preempting vector");
        eoi();
        read_isr(rd); chk("R8 eoi clears best level", rd, 8'h04);
        chk("R8 still blocked", {7'd0, int_o}, 8'h00);
        eoi();
        chk("R8 eoi releases waiting level", {7'd0, int_o}, 8'h01);
        do_ack(8'h34, "R6 vector level 5");
        read_pending(rd); chk("R2 held line does not retrigger", rd, 8'h00);
        eoi();
        chk("R2 no interrupt while lines held", {7'd0, int_o}, 8'h00);
        set_ir(8'h00);

        // R4 mask
        host_write(1'b1, 8'h01);
        set_ir(8'h09);
        chk("R4 unmasked line served", {7'd0, int_o}, 8'h01);
        do_ack(8'h2C, "R4 masked level 0 skipped");
        host_read(1'b1, rd); chk("R10 mask readback", rd, 8'h01);
        eoi();
        read_pending(rd); chk("R4 masked request stays pending", rd, 8'h01);
        chk("R4 masked request silent", {7'd0, int_o}, 8'h00);
        host_write(1'b1, 8'h00);
        chk("R4 unmask releases request", {7'd0, int_o}, 8'h01);
        do_ack(8'h20, "R4 vector level 0");
        eoi();
        set_ir(8'h00);

        // R6 spacing of 8
        set_cfg(8'h05);
        set_ir(8'h80);
        do_ack(8'h58, "R6 spacing 8 level 7");
        eoi();
        set_ir(8'h00);

        // R9 rotating priority
        set_cfg(8'h03);
        set_ir(8'h04);
        do_ack(8'h28, "R9 first rotation vector");
        eoi();
        set_ir(8'h00);
        set_ir(8'h12);
        do_ack(8'h30, "R9 level 4 beats level 1 after rotation");
        chk("R9 rotated lower level blocked", {7'd0, int_o}, 8'h00);
        eoi();
        do_ack(8'h24, "R9 level 1 served next");
        eoi();
        set_ir(8'h00);
        set_ir(8'h05);
        do_ack(8'h28, "R9 level 2 beats level 0");
        eoi();
        do_ack(8'h20, "R9 level 0 last");
        eoi();
        set_ir(8'h00);

        // R3 level mode
        set_cfg(8'h00);
        set_ir(8'h40);
        chk("R3 level raises int", {7'd0, int_o}, 8'h01);
        read_pending(rd); chk("R3 pending follows high", rd, 8'h40);
        set_ir(8'h00);
        chk("R3 int drops with line", {7'd0, int_o}, 8'h00);
        read_pending(rd); chk("R3 pending follows low", rd, 8'h00);
        set_ir(8'h40);
        do_ack(8'h38, "R3 level vector");
        read_pending(rd); chk("R3 pending returns while high", rd, 8'h40);
        chk("R7 equal level waits", {7'd0, int_o}, 8'h00);
        eoi();
        chk("R8 equal level released", {7'd0, int_o}, 8'h01);
        do_ack(8'h38, "R3 second level vector");
        eoi();
        set_ir(8'h00);

        // R6 acknowledge with interrupt low is ignored
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        chk("R6 idle ack keeps vector", vec, 8'h38);
        read_isr(rd); chk("R6 idle ack keeps in-service", rd, 8'h00);

        // R11 acknowledge and end of service together
        set_cfg(8'h01);
        set_ir(8'h08);
        do_ack(8'h2C, "R11 setup level 3");
        set_ir(8'h0A);
        ack_with_eoi(8'h24, "R11 same-cycle vector");
        read_isr(rd); chk("R11 same-cycle in-service", rd, 8'h02);
        eoi();
        read_isr(rd); chk("R8 in-service empty", rd, 8'h00);
        set_ir(8'h00);

        repeat (2) @(negedge clk);
        chk("R6 all expected vectors seen", 8'(exp_q.size()), 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule